// File: doc/BRIEF.md
# Programmable Chip-Select Wait-State Unit

This unit sits between a simple bus master and a set of external static memories and peripherals. Every transfer address is compared against several programmable windows. The winning window gets its active-low chip select, and its own read-enable or write-enable strobe. The unit counts a programmed number of wait states and then returns a one-cycle acknowledge to the master. Addresses that hit no window get a one-cycle error response, and no strobe is driven.

Each window has a base address, a power-of-two size, a port width and two wait counts. The first wait count applies to the opening beat of an access. The second wait count applies to every follow-on beat. An access wider than the port of its window is split into beats, and the unit drives the address of each beat. An active-low address-valid strobe marks the first cycle of every beat, for flash devices that latch the address on it. After the acknowledge, the chip select is held for one extra cycle so that the device has address hold time.

Top module: `csu_top`

## Requirements
- R1: After reset all chip selects, read enables, write enables and the address-valid strobe are high, and acknowledge, error and busy are low.
- R2: A window matches when every address bit at or above its size exponent equals the same bit of its base. During the access only that window's chip select is low.
- R3: A window never matches if any of these holds: it is disabled, its base has a set bit below its size exponent, its size exponent is below the minimum (16, i.e. 64 KiB) or not below the address width, or its port-width code is 3.
- R4: When several windows match, the one with the lowest index is selected.
- R5: A request that matches no window, or that uses access-size code 3, pulses error for exactly the cycle after the request. No strobe is driven and the unit is idle again in the cycle after that.
- R6: The first beat lasts first-wait + 1 cycles, counted from the cycle after the request. The read enable (on a read) or the write enable (on a write) of the selected window is low in every cycle of every beat.
- R7: Port-width codes 0/1/2 mean 8/16/32 bits, and access-size codes 0/1/2 mean byte/halfword/word. An access splits into 2^(size-width) beats when its size code exceeds the width code, and into one beat otherwise. Beat k drives the address start + k * port bytes.
- R8: Each beat after the first lasts next-wait + 1 cycles.
- R9: Address-valid is low in exactly the first cycle of each beat.
- R10: Acknowledge is high in the last cycle of the last beat only. In the following cycle the chip select stays low with both strobes high, and one cycle later the chip select is high and busy is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_req | input | 1 | Start a transfer, sampled while not busy |
| bus_addr | input | ADDR_W | Transfer start address |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_size | input | 2 | Access size code |
| bus_ack | output | 1 | Transfer complete |
| bus_err | output | 1 | Transfer rejected |
| bus_busy | output | 1 | Unit occupied |
| cfg_en | input | NUM_WIN | Per-window enable |
| cfg_base | input | NUM_WIN*ADDR_W | Per-window base address |
| cfg_size_log2 | input | NUM_WIN*SZL_W | Per-window size exponent |
| cfg_port_width | input | NUM_WIN*2 | Per-window port-width code |
| cfg_wait_first | input | NUM_WIN*WAIT_W | Wait states of the first beat |
| cfg_wait_next | input | NUM_WIN*WAIT_W | Wait states of each later beat |
| mem_cs_n | output | NUM_WIN | Active-low chip selects |
| mem_rd_n | output | NUM_WIN | Active-low read enables |
| mem_wr_n | output | NUM_WIN | Active-low write enables |
| mem_adv_n | output | 1 | Active-low address valid |
| mem_addr | output | ADDR_W | Address of the current beat |

## Verification
The bench builds the unit with four windows, a 24-bit address and 3-bit wait counters. With a 24-bit address, a size exponent equal to or above the address width can be programmed and its rejection observed. The 3-bit counters let the bench use the largest wait value, 7, in a short run. Four windows are enough to set up one overlapping pair for priority, one window with an 8-bit port that needs four beats, and a spare window for the rejection cases.

// File: rtl/csu_pkg.sv
package csu_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_BEAT  = 2'd1,
      ST_HOLD  = 2'd2,
      ST_FAULT = 2'd3
   } csu_state_e;

   localparam logic [1:0] PW_BAD   = 2'd3;
   localparam logic [1:0] SIZE_BAD = 2'd3;

   // log2 of the number of beats for an access size on a port width
   function automatic logic [1:0] beats_log2(input logic [1:0] size_code,
                                             input logic [1:0] pw_code);
      return (size_code > pw_code) ? (size_code - pw_code) : 2'd0;
   endfunction

   // index of the last beat for a given beats_log2
   function automatic logic [1:0] last_beat(input logic [1:0] blog);
      case (blog)
         2'd0:    return 2'd0;
         2'd1:    return 2'd1;
         default: return 2'd3;
      endcase
   endfunction

endpackage

// File: rtl/csu_win_match.sv
module csu_win_match #(
   parameter int ADDR_W    = 32,
   parameter int SZL_W     = 5,
   parameter int MIN_LOG2  = 16
) (
   input  logic              en,
   input  logic [ADDR_W-1:0] base,
   input  logic [SZL_W-1:0]  size_log2,
   input  logic [1:0]        port_width,
   input  logic [ADDR_W-1:0] addr,
   output logic              hit
);
   import csu_pkg::*;

   logic [ADDR_W-1:0] low_mask;
   logic              aligned;
   logic              size_ok;
   logic              pw_ok;

   always_comb begin
      low_mask = ~({ADDR_W{1'b1}} << size_log2);
      aligned  = ((base & low_mask) == '0);
      size_ok  = (32'(size_log2) >= MIN_LOG2) && (32'(size_log2) < ADDR_W);
      pw_ok    = (port_width != PW_BAD);
      hit      = en && aligned && size_ok && pw_ok &&
                 (((addr ^ base) & ~low_mask) == '0);
   end

endmodule

// File: rtl/csu_prio_pick.sv
module csu_prio_pick #(
   parameter int N     = 4,
   parameter int IDX_W = 2
) (
   input  logic [N-1:0]     hits,
   output logic             any,
   output logic [IDX_W-1:0] idx
);
   always_comb begin
      any = |hits;
      idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (hits[i]) idx = IDX_W'(i);
      end
   end

endmodule

// File: rtl/csu_beat_seq.sv
module csu_beat_seq #(
   parameter int ADDR_W = 32,
   parameter int WAIT_W = 4,
   parameter int IDX_W  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              go,
   input  logic              fault,
   input  logic [ADDR_W-1:0] start_addr,
   input  logic              start_wr,
   input  logic [IDX_W-1:0]  start_idx,
   input  logic [1:0]        start_pw,
   input  logic [1:0]        start_blog,
   input  logic [WAIT_W-1:0] start_wait1,
   input  logic [WAIT_W-1:0] start_wait2,
   output logic              busy,
   output logic              ack,
   output logic              err,
   output logic              adv,
   output logic              cs_act,
   output logic              strobe_act,
   output logic              cur_wr,
   output logic [IDX_W-1:0]  cur_idx,
   output logic [ADDR_W-1:0] beat_addr
);
   import csu_pkg::*;

   csu_state_e        state_q;
   logic [WAIT_W-1:0] cnt_q;
   logic [WAIT_W-1:0] wait2_q;
   logic [1:0]        beat_q;
   logic [1:0]        last_q;
   logic [1:0]        pw_q;
   logic              first_q;
   logic              wr_q;
   logic [IDX_W-1:0]  idx_q;
   logic [ADDR_W-1:0] addr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         cnt_q   <= '0;
         wait2_q <= '0;
         beat_q  <= '0;
         last_q  <= '0;
         pw_q    <= '0;
         first_q <= 1'b0;
         wr_q    <= 1'b0;
         idx_q   <= '0;
         addr_q  <= '0;
      end else begin
         case (state_q)
            ST_IDLE: begin
               if (go) begin
                  state_q <= ST_BEAT;
                  cnt_q   <= start_wait1;
                  wait2_q <= start_wait2;
                  beat_q  <= '0;
                  last_q  <= last_beat(start_blog);
                  pw_q    <= start_pw;
                  first_q <= 1'b1;
                  wr_q    <= start_wr;
                  idx_q   <= start_idx;
                  addr_q  <= start_addr;
               end else if (fault) begin
                  state_q <= ST_FAULT;
               end
            end
            ST_BEAT: begin
               first_q <= 1'b0;
               if (cnt_q != '0) begin
                  cnt_q <= cnt_q - 1'b1;
               end else if (beat_q == last_q) begin
                  state_q <= ST_HOLD;
               end else begin
                  beat_q  <= beat_q + 2'd1;
                  cnt_q   <= wait2_q;
                  first_q <= 1'b1;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      busy       = (state_q != ST_IDLE);
      strobe_act = (state_q == ST_BEAT);
      cs_act     = (state_q == ST_BEAT) || (state_q == ST_HOLD);
      ack        = strobe_act && (cnt_q == '0) && (beat_q == last_q);
      err        = (state_q == ST_FAULT);
      adv        = strobe_act && first_q;
      cur_wr     = wr_q;
      cur_idx    = idx_q;
      beat_addr  = addr_q + (ADDR_W'(beat_q) << pw_q);
   end

   // R7: the beat index never runs past the last beat of the access
   assert_beat_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_BEAT) |-> (beat_q <= last_q));

   // R8: a new follow-on beat reloads its counter from the second wait count
   assert_next_wait_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (strobe_act && cnt_q == '0 && beat_q != last_q) |=> (cnt_q == wait2_q && first_q));

   // R5: a fault lasts exactly one cycle
   assert_fault_once_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_FAULT) |=> (state_q == ST_IDLE));

endmodule

// File: rtl/csu_top.sv
module csu_top #(
   parameter int NUM_WIN       = 4,
   parameter int ADDR_W        = 32,
   parameter int WAIT_W        = 4,
   parameter int MIN_SIZE_LOG2 = 16,
   localparam int SZL_W        = $clog2(ADDR_W),
   localparam int IDX_W        = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      bus_req,
   input  logic [ADDR_W-1:0]         bus_addr,
   input  logic                      bus_wr,
   input  logic [1:0]                bus_size,
   output logic                      bus_ack,
   output logic                      bus_err,
   output logic                      bus_busy,
   input  logic [NUM_WIN-1:0]        cfg_en,
   input  logic [NUM_WIN*ADDR_W-1:0] cfg_base,
   input  logic [NUM_WIN*SZL_W-1:0]  cfg_size_log2,
   input  logic [NUM_WIN*2-1:0]      cfg_port_width,
   input  logic [NUM_WIN*WAIT_W-1:0] cfg_wait_first,
   input  logic [NUM_WIN*WAIT_W-1:0] cfg_wait_next,
   output logic [NUM_WIN-1:0]        mem_cs_n,
   output logic [NUM_WIN-1:0]        mem_rd_n,
   output logic [NUM_WIN-1:0]        mem_wr_n,
   output logic                      mem_adv_n,
   output logic [ADDR_W-1:0]         mem_addr
);
   import csu_pkg::*;

   if (NUM_WIN < 1) begin : g_bad_num
      $error("csu_top: NUM_WIN must be at least 1");
   end
   if (MIN_SIZE_LOG2 < 1 || MIN_SIZE_LOG2 >= ADDR_W) begin : g_bad_min
      $error("csu_top: MIN_SIZE_LOG2 must lie inside the address width");
   end
   if (WAIT_W < 1) begin : g_bad_wait
      $error("csu_top: WAIT_W must be at least 1");
   end

   logic [NUM_WIN-1:0] hits;
   logic               any_hit;
   logic [IDX_W-1:0]   win_idx;

   for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
      csu_win_match #(
         .ADDR_W   (ADDR_W),
         .SZL_W    (SZL_W),
         .MIN_LOG2 (MIN_SIZE_LOG2)
      ) u_match (
         .en         (cfg_en[w]),
         .base       (cfg_base[w*ADDR_W +: ADDR_W]),
         .size_log2  (cfg_size_log2[w*SZL_W +: SZL_W]),
         .port_width (cfg_port_width[w*2 +: 2]),
         .addr       (bus_addr),
         .hit        (hits[w])
      );
   end

   csu_prio_pick #(.N(NUM_WIN), .IDX_W(IDX_W)) u_pick (
      .hits (hits),
      .any  (any_hit),
      .idx  (win_idx)
   );

   logic [1:0]        sel_pw;
   logic [WAIT_W-1:0] sel_w1;
   logic [WAIT_W-1:0] sel_w2;

   always_comb begin
      sel_pw = '0;
      sel_w1 = '0;
      sel_w2 = '0;
      for (int i = 0; i < NUM_WIN; i++) begin
         if (win_idx == IDX_W'(i)) begin
            sel_pw = cfg_port_width[i*2 +: 2];
            sel_w1 = cfg_wait_first[i*WAIT_W +: WAIT_W];
            sel_w2 = cfg_wait_next[i*WAIT_W +: WAIT_W];
         end
      end
   end

   logic start, go, fault;
   logic cs_act, strobe_act, adv, cur_wr;
   logic [IDX_W-1:0] cur_idx;

   assign start = bus_req && !bus_busy;
   assign go    = start && any_hit && (bus_size != SIZE_BAD);
   assign fault = start && !(any_hit && (bus_size != SIZE_BAD));

   csu_beat_seq #(
      .ADDR_W (ADDR_W),
      .WAIT_W (WAIT_W),
      .IDX_W  (IDX_W)
   ) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .go          (go),
      .fault       (fault),
      .start_addr  (bus_addr),
      .start_wr    (bus_wr),
      .start_idx   (win_idx),
      .start_pw    (sel_pw),
      .start_blog  (beats_log2(bus_size, sel_pw)),
      .start_wait1 (sel_w1),
      .start_wait2 (sel_w2),
      .busy        (bus_busy),
      .ack         (bus_ack),
      .err         (bus_err),
      .adv         (adv),
      .cs_act      (cs_act),
      .strobe_act  (strobe_act),
      .cur_wr      (cur_wr),
      .cur_idx     (cur_idx),
      .beat_addr   (mem_addr)
   );

   always_comb begin
      mem_cs_n  = '1;
      mem_rd_n  = '1;
      mem_wr_n  = '1;
      mem_adv_n = !adv;
      for (int i = 0; i < NUM_WIN; i++) begin
         if (cur_idx == IDX_W'(i)) begin
            mem_cs_n[i] = !cs_act;
            mem_rd_n[i] = !(strobe_act && !cur_wr);
            mem_wr_n[i] = !(strobe_act && cur_wr);
         end
      end
   end

   // R2: at most one chip select is active
   assert_cs_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(~mem_cs_n));

   // R6: a strobe is only driven inside an active chip select
   assert_strobe_in_cs_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ((~mem_rd_n | ~mem_wr_n) & mem_cs_n) == '0);

   // R5: error and acknowledge never coincide, and error drives no chip select
   assert_err_clean_R5: assert property (@(posedge clk) disable iff (!rst_n)
      bus_err |-> (!bus_ack && (&mem_cs_n)));

   // R9: an accepted access opens with address valid
   assert_open_adv_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(bus_busy) && !bus_err) |-> !mem_adv_n);

   // R10: hold cycle after acknowledge, then release
   assert_hold_after_ack_R10: assert property (@(posedge clk) disable iff (!rst_n)
      bus_ack |=> (!(&mem_cs_n) && (&mem_rd_n) && (&mem_wr_n) && !bus_ack));
   assert_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
      bus_ack |=> ##1 ((&mem_cs_n) && !bus_busy));

endmodule

// File: tb/csu_top_tb.sv
module csu_top_tb_top;
   localparam int NW  = 4;
   localparam int AW  = 24;
   localparam int WW  = 3;
   localparam int SLW = $clog2(AW);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   logic          bus_req = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic          bus_wr = 1'b0;
   logic [1:0]    bus_size = 2'd0;
   logic          bus_ack, bus_err, bus_busy;
   logic [NW-1:0]    cfg_en = '0;
   logic [NW*AW-1:0] cfg_base = '0;
   logic [NW*SLW-1:0] cfg_size_log2 = '0;
   logic [NW*2-1:0]  cfg_port_width = '0;
   logic [NW*WW-1:0] cfg_wait_first = '0;
   logic [NW*WW-1:0] cfg_wait_next = '0;
   logic [NW-1:0] mem_cs_n, mem_rd_n, mem_wr_n;
   logic          mem_adv_n;
   logic [AW-1:0] mem_addr;

   csu_top #(.NUM_WIN(NW), .ADDR_W(AW), .WAIT_W(WW), .MIN_SIZE_LOG2(16)) dut_i (
      .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_addr(bus_addr),
      .bus_wr(bus_wr), .bus_size(bus_size), .bus_ack(bus_ack), .bus_err(bus_err),
      .bus_busy(bus_busy), .cfg_en(cfg_en), .cfg_base(cfg_base),
      .cfg_size_log2(cfg_size_log2), .cfg_port_width(cfg_port_width),
      .cfg_wait_first(cfg_wait_first), .cfg_wait_next(cfg_wait_next),
      .mem_cs_n(mem_cs_n), .mem_rd_n(mem_rd_n), .mem_wr_n(mem_wr_n),
      .mem_adv_n(mem_adv_n), .mem_addr(mem_addr)
   );

   int n_checks = 0;
   int n_errors = 0;
   bit done = 1'b0;

   // window settings kept by the bench for its expectations
   int  w_pw [NW];
   int  w_w1 [NW];
   int  w_w2 [NW];

   task automatic chk(input bit ok, input string tag,
                      input logic [63:0] act, input logic [63:0] exp);
      n_checks++;
      if (!ok) begin
         n_errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // {busy, ack, err, adv_n, cs_n, rd_n, wr_n, addr}
   function automatic logic [63:0] pack_obs(input bit with_addr);
      return {23'd0, bus_busy, bus_ack, bus_err, mem_adv_n, mem_cs_n, mem_rd_n,
              mem_wr_n, (with_addr ? mem_addr : {AW{1'b0}})};
   endfunction

   function automatic logic [63:0] pack_exp(input bit busy, ack, err, adv_n,
                                            input logic [NW-1:0] cs, rd, wr,
                                            input logic [AW-1:0] addr);
      return {23'd0, busy, ack, err, adv_n, cs, rd, wr, addr};
   endfunction

   task automatic set_win(input int i, input bit en, input logic [AW-1:0] base,
                          input int slog, input int pw, input int w1, input int w2);
      cfg_en[i] = en;
      cfg_base[i*AW +: AW] = base;
      cfg_size_log2[i*SLW +: SLW] = SLW'(slog);
      cfg_port_width[i*2 +: 2] = 2'(pw);
      cfg_wait_first[i*WW +: WW] = WW'(w1);
      cfg_wait_next[i*WW +: WW] = WW'(w2);
      w_pw[i] = pw; w_w1[i] = w1; w_w2[i] = w2;
   endtask

   task automatic issue(input logic [AW-1:0] a, input bit wr, input int sz);
      bus_addr = a; bus_wr = wr; bus_size = 2'(sz); bus_req = 1'b1;
      @(posedge clk);
      @(negedge clk);
      bus_req = 1'b0;
   endtask

   // full access with per-cycle expectations derived from the requirements
   task automatic run_access(input string tag, input logic [AW-1:0] a,
                             input bit wr, input int sz, input int win);
      int pw = w_pw[win];
      int nb = (sz > pw) ? (1 << (sz - pw)) : 1;
      logic [NW-1:0] sel = ~(NW'(1) << win);
      logic [AW-1:0] last_addr = a;
      issue(a, wr, sz);
      for (int b = 0; b < nb; b++) begin
         int len = ((b == 0) ? w_w1[win] : w_w2[win]) + 1;
         logic [AW-1:0] ba = a + AW'(b << pw);
         last_addr = ba;
         for (int p = 0; p < len; p++) begin
            logic [63:0] e = pack_exp(1'b1, (b == nb - 1) && (p == len - 1), 1'b0,
                                      p != 0, sel, wr ? '1 : sel, wr ? sel : '1, ba);
            chk(pack_obs(1'b1) == e, tag, pack_obs(1'b1), e);
            @(negedge clk);
         end
      end
      begin
         logic [63:0] e = pack_exp(1'b1, 1'b0, 1'b0, 1'b1, sel, '1, '1, last_addr);
         chk(pack_obs(1'b1) == e, {tag, " R10 hold"}, pack_obs(1'b1), e);
      end
      @(negedge clk);
      begin
         logic [63:0] e = pack_exp(1'b0, 1'b0, 1'b0, 1'b1, '1, '1, '1, '0);
         chk(pack_obs(1'b0) == e, {tag, " R10 release"}, pack_obs(1'b0), e);
      end
   endtask

   task automatic run_error(input string tag, input logic [AW-1:0] a, input int sz);
      logic [63:0] e;
      issue(a, 1'b0, sz);
      e = pack_exp(1'b1, 1'b0, 1'b1, 1'b1, '1, '1, '1, '0);
      chk(pack_obs(1'b0) == e, tag, pack_obs(1'b0), e);
      @(negedge clk);
      e = pack_exp(1'b0, 1'b0, 1'b0, 1'b1, '1, '1, '1, '0);
      chk(pack_obs(1'b0) == e, {tag, " idle"}, pack_obs(1'b0), e);
   endtask

   task automatic t_reset();
      logic [63:0] e = pack_exp(1'b0, 1'b0, 1'b0, 1'b1, '1, '1, '1, '0);
      chk(pack_obs(1'b0) == e, "R1 reset", pack_obs(1'b0), e);
   endtask

   task automatic t_single_beat();
      run_access("R2 R6 win0 word read", 24'h100010, 1'b0, 2, 0);
      run_access("R2 R6 win0 byte write", 24'h1ABCDE, 1'b1, 0, 0);
   endtask

   task automatic t_split();
      run_access("R7 R8 R9 win1 word read 4 beats", 24'h200003, 1'b0, 2, 1);
      run_access("R7 R8 win1 half write 2 beats", 24'h21FFF0, 1'b1, 1, 1);
      run_access("R6 win3 half read max wait", 24'h420000, 1'b0, 1, 3);
      run_access("R7 R8 win3 word write 2 beats", 24'h43FF00, 1'b1, 2, 3);
   endtask

   task automatic t_priority();
      run_access("R4 overlap picks win2", 24'h400010, 1'b0, 2, 2);
      run_access("R4 overlap picks win2 write", 24'h40FFFC, 1'b1, 0, 2);
   endtask

   task automatic t_errors();
      run_error("R5 no window", 24'h800000, 2);
      run_error("R5 size code 3", 24'h100000, 3);
   endtask

   task automatic t_reject();
      set_win(0, 1'b1, 24'h180000, 20, 2, 2, 1);
      run_error("R3 misaligned base", 24'h180000, 2);
      set_win(0, 1'b1, 24'h100000, 15, 2, 2, 1);
      run_error("R3 size below minimum", 24'h100000, 2);
      set_win(0, 1'b1, 24'h000000, 24, 2, 2, 1);
      run_error("R3 size not below width", 24'h000100, 2);
      set_win(0, 1'b1, 24'h100000, 20, 3, 2, 1);
      run_error("R3 width code 3", 24'h100000, 2);
      set_win(0, 1'b0, 24'h100000, 20, 2, 2, 1);
      run_error("R3 disabled", 24'h100000, 2);
      set_win(0, 1'b1, 24'h100000, 20, 2, 2, 1);
      run_access("R3 restored win0", 24'h100000, 1'b0, 2, 0);
   endtask

   initial begin
      set_win(0, 1'b1, 24'h100000, 20, 2, 2, 1);
      set_win(1, 1'b1, 24'h200000, 17, 0, 1, 0);
      set_win(2, 1'b1, 24'h400000, 16, 2, 0, 0);
      set_win(3, 1'b1, 24'h400000, 18, 1, 7, 2);
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_single_beat();
      t_split();
      t_priority();
      t_errors();
      t_reject();
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (20000) @(posedge clk);
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end

endmodule